// File: doc/BRIEF.md
# Freefall and Motion Event Detector

This block watches a stream of signed three-axis acceleration samples, one set per cycle in which `smp_valid` is high. It checks each enabled axis against one programmable magnitude threshold. In motion mode the condition holds when any enabled axis is above the threshold. In freefall mode it holds when every enabled axis is below it.

A debounce counter, counted in samples, qualifies the raw condition before `evt_active` rises. Two counter policies set how the event falls again:

- **Decrement:** each sample without the condition steps the counter down.
- **Restart:** the first sample without the condition clears the counter.

With the latch enabled, a raised event stays up until software reads the source register, which the block sees as the `src_rd` strobe. For that same period, the per-axis flags keep the values they captured from the triggering sample.

The per-axis outputs have no debounce. They report which enabled axes are above the threshold and the sign of each of those axes. Filtering of the samples and routing of the event to interrupt pins happen outside this block.

Top module: `accel_event_detect`

## Requirements
- R1: On each valid sample, `axis_hit[i]` is set when axis i is enabled and its magnitude, the absolute value of the signed sample (so -2048 counts as 2048), is strictly greater than `cfg_thresh`. Bit 0 is X, bit 1 is Y and bit 2 is Z, here and in every per-axis field.
- R2: `axis_neg[i]` is 1 only when `axis_hit[i]` is set by the same sample and that sample is negative.
- R3: With `cfg_motion`=1 the condition is that some enabled axis is strictly above the threshold. With `cfg_motion`=0 it is that every enabled axis is strictly below the threshold. With `cfg_axis_en`=000 there is never a condition and no axis flag is set.
- R4: `evt_active` rises on the `cfg_dbnc`-th consecutive condition sample. With `cfg_dbnc`=0 it rises on the first condition sample.
- R5: Decrement policy (`cfg_clr_mode`=0), without the latch: each sample without the condition lowers the counter by one, stopping at zero. `evt_active` falls on the sample that brings the counter to zero.
- R6: Restart policy (`cfg_clr_mode`=1), without the latch: the first sample without the condition zeroes the counter and drops `evt_active`. Raising it again takes `cfg_dbnc` new condition samples.
- R7: With `cfg_latch`=0, `src_rd` changes neither `evt_active` nor the counter.
- R8: With `cfg_latch`=1, `evt_active` stays high through samples without the condition until `src_rd`. That read clears both the event and the counter.
- R9: With `cfg_latch`=1 and `evt_active` high, `axis_hit` and `axis_neg` hold their values. They update again from the cycle of the read.
- R10: When `src_rd` and a valid sample fall in the same cycle in latched mode, the read takes priority. That sample does not count toward the debounce, but the axis flags take their values from it.
- R11: The counter saturates at `cfg_dbnc`. With the decrement policy, any number of condition samples beyond `cfg_dbnc` still leaves exactly `cfg_dbnc` samples without the condition before the event falls.
- R12: A synchronous active-high `rst` clears `evt_active`, `axis_hit`, `axis_neg` and the counter.
- R13: In a cycle with `smp_valid` low and no latched read, no output and no counter value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe marking a new three-axis sample |
| smp_x | input | DW | Signed X sample |
| smp_y | input | DW | Signed Y sample |
| smp_z | input | DW | Signed Z sample |
| cfg_motion | input | 1 | 1 selects motion, 0 selects freefall |
| cfg_latch | input | 1 | 1 holds the event until a source read |
| cfg_clr_mode | input | 1 | Debounce policy: 0 decrement, 1 restart |
| cfg_axis_en | input | 3 | Per-axis enable, bit 0 X |
| cfg_thresh | input | DW | Unsigned magnitude threshold |
| cfg_dbnc | input | CW | Debounce length in samples |
| src_rd | input | 1 | Strobe signalling that the source register was read |
| evt_active | output | 1 | Debounced event flag |
| axis_hit | output | 3 | Per-axis above-threshold flags |
| axis_neg | output | 3 | Per-axis negative-sign flags |

## Verification
The collision that matters is a source read and a valid sample arriving in the same cycle in latched mode. There, the read that clears the event meets a sample that would otherwise advance the counter and reload the axis flags. The bench drives both strobes together while the event is latched, with the sample carrying a strong Z reading.

It then checks three things:

- `evt_active` is low after that cycle.
- The axis flags show the Z reading.
- The event rises again only after the full debounce count of further samples, which proves the colliding sample was not counted.

// File: rtl/accel_evt_pkg.sv
package accel_evt_pkg;
  localparam int NUM_AXES = 3;

  typedef enum logic {
    DB_DECREMENT = 1'b0,
    DB_RESTART   = 1'b1
  } db_mode_e;
endpackage

// File: rtl/evt_axis_cmp.sv
module evt_axis_cmp #(
  parameter int DW = 12
) (
  input  logic signed [DW-1:0] smp,
  input  logic        [DW-1:0] thr,
  output logic                 above,
  output logic                 below,
  output logic                 neg
);
  logic [DW-1:0] mag;

  // Two's complement absolute value; the most negative code maps to 2^(DW-1).
  always_comb begin
    mag   = smp[DW-1] ? (~smp + 1'b1) : smp;
    above = (mag > thr);
    below = (mag < thr);
    neg   = smp[DW-1];
  end
endmodule

// File: rtl/evt_debounce.sv
module evt_debounce
  import accel_evt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic          cond,
  input  db_mode_e      mode,
  input  logic          latch,
  input  logic          rd,
  input  logic [CW-1:0] dbnc,
  output logic          evt
);
  logic [CW-1:0] cnt_q, cnt_inc, cnt_dec, cnt_nxt;
  logic          evt_q, evt_nxt, rd_clr;

  assign rd_clr = latch & rd;

  always_comb begin
    cnt_inc = (cnt_q >= dbnc) ? dbnc : cnt_q + 1'b1;
    if (cnt_q == '0)
      cnt_dec = '0;
    else if ((cnt_q - 1'b1) > dbnc)
      cnt_dec = dbnc;
    else
      cnt_dec = cnt_q - 1'b1;

    if (cond)
      cnt_nxt = cnt_inc;
    else if (mode == DB_RESTART)
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_dec;

    evt_nxt = evt_q;
    if (cond && (cnt_nxt >= dbnc))
      evt_nxt = 1'b1;
    else if (!cond && !latch && ((mode == DB_RESTART) || (cnt_nxt == '0)))
      evt_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (rd_clr) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (smp_valid) begin
      cnt_q <= cnt_nxt;
      evt_q <= evt_nxt;
    end
  end

  assign evt = evt_q;

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (latch && rd) |=> (!evt_q && cnt_q == '0));

  assert_latched_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (latch && evt_q && !rd) |=> evt_q);

  assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !rd_clr) |=> (cnt_q <= $past(dbnc)));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !rd_clr) |=> ($stable(evt_q) && $stable(cnt_q)));

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !rd_clr && !cond && mode == DB_RESTART) |=> (cnt_q == '0));
endmodule

// File: rtl/accel_event_detect.sv
module accel_event_detect
  import accel_evt_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [DW-1:0]       smp_x,
  input  logic signed [DW-1:0]       smp_y,
  input  logic signed [DW-1:0]       smp_z,
  input  logic                       cfg_motion,
  input  logic                       cfg_latch,
  input  logic                       cfg_clr_mode,
  input  logic [NUM_AXES-1:0]        cfg_axis_en,
  input  logic [DW-1:0]              cfg_thresh,
  input  logic [CW-1:0]              cfg_dbnc,
  input  logic                       src_rd,
  output logic                       evt_active,
  output logic [NUM_AXES-1:0]        axis_hit,
  output logic [NUM_AXES-1:0]        axis_neg
);
  logic signed [DW-1:0] smp_arr [NUM_AXES];
  logic [NUM_AXES-1:0]  above, below, negb;
  logic [NUM_AXES-1:0]  hit_q, neg_q;
  logic                 cond, freeze;

  assign smp_arr[0] = smp_x;
  assign smp_arr[1] = smp_y;
  assign smp_arr[2] = smp_z;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    evt_axis_cmp #(.DW(DW)) u_cmp (
      .smp   (smp_arr[a]),
      .thr   (cfg_thresh),
      .above (above[a]),
      .below (below[a]),
      .neg   (negb[a])
    );
  end

  always_comb begin
    if (cfg_axis_en == '0)
      cond = 1'b0;
    else if (cfg_motion)
      cond = |(cfg_axis_en & above);
    else
      cond = &(~cfg_axis_en | below);
  end

  evt_debounce #(.CW(CW)) u_dbnc (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .cond      (cond),
    .mode      (db_mode_e'(cfg_clr_mode)),
    .latch     (cfg_latch),
    .rd        (src_rd),
    .dbnc      (cfg_dbnc),
    .evt       (evt_active)
  );

  assign freeze = cfg_latch & evt_active & ~src_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
      neg_q <= '0;
    end else if (smp_valid && !freeze) begin
      hit_q <= cfg_axis_en & above;
      neg_q <= cfg_axis_en & above & negb;
    end
  end

  assign axis_hit = hit_q;
  assign axis_neg = neg_q;

  assert_freeze_holds_R9: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(hit_q) && $stable(neg_q)));

  assert_disabled_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !freeze && cfg_axis_en == '0) |=> (hit_q == '0));

  assert_neg_needs_hit_R2: assert property (@(posedge clk) disable iff (rst)
    ((neg_q & ~hit_q) == '0));

  assert_unlatched_read_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_latch && src_rd && !smp_valid) |=> $stable(evt_active));
endmodule

// File: tb/accel_event_detect_bench.sv
module accel_event_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [11:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic cfg_motion = 1'b1, cfg_latch = 1'b0, cfg_clr_mode = 1'b0;
  logic [2:0] cfg_axis_en = 3'b111;
  logic [11:0] cfg_thresh = 12'd100;
  logic [7:0] cfg_dbnc = 8'd2;
  logic src_rd = 1'b0;
  logic evt_active;
  logic [2:0] axis_hit, axis_neg;

  int nchecks = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_event_detect u_accel_event_detect (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .cfg_motion(cfg_motion), .cfg_latch(cfg_latch), .cfg_clr_mode(cfg_clr_mode),
    .cfg_axis_en(cfg_axis_en), .cfg_thresh(cfg_thresh), .cfg_dbnc(cfg_dbnc),
    .src_rd(src_rd), .evt_active(evt_active), .axis_hit(axis_hit), .axis_neg(axis_neg)
  );

  // Row: {motion, latch, clr_mode, en[2:0], rd, x, y, z, exp_evt, exp_hit[2:0], exp_neg[2:0]}
  // Threshold 100, debounce 2 throughout the table.
  localparam logic [49:0] TBL [NV] = '{
    {3'b100, 3'b111, 1'b0, 12'(50),    12'(0),     12'(0),    1'b0, 3'b000, 3'b000}, // R3 below
    {3'b100, 3'b111, 1'b0, 12'(101),   12'(0),     12'(0),    1'b0, 3'b001, 3'b000}, // R1 count 1
    {3'b100, 3'b111, 1'b0, 12'(-150),  12'(0),     12'(0),    1'b1, 3'b001, 3'b001}, // R4 R2
    {3'b100, 3'b111, 1'b0, 12'(100),   12'(0),     12'(0),    1'b1, 3'b000, 3'b000}, // R1 equal, R5
    {3'b100, 3'b111, 1'b0, 12'(0),     12'(0),     12'(0),    1'b0, 3'b000, 3'b000}, // R5 falls
    {3'b100, 3'b111, 1'b0, 12'(0),     12'(-2048), 12'(0),    1'b0, 3'b010, 3'b010}, // R1 min code
    {3'b100, 3'b111, 1'b1, 12'(0),     12'(0),     12'(200),  1'b1, 3'b100, 3'b000}, // R7
    {3'b100, 3'b111, 1'b1, 12'(0),     12'(0),     12'(0),    1'b1, 3'b000, 3'b000}, // R7
    {3'b100, 3'b111, 1'b0, 12'(0),     12'(0),     12'(0),    1'b0, 3'b000, 3'b000}, // R5
    {3'b101, 3'b111, 1'b0, 12'(300),   12'(0),     12'(0),    1'b0, 3'b001, 3'b000}, // R6
    {3'b101, 3'b111, 1'b0, 12'(300),   12'(0),     12'(0),    1'b1, 3'b001, 3'b000}, // R6
    {3'b101, 3'b111, 1'b0, 12'(0),     12'(0),     12'(0),    1'b0, 3'b000, 3'b000}, // R6 drop
    {3'b101, 3'b111, 1'b0, 12'(300),   12'(0),     12'(0),    1'b0, 3'b001, 3'b000}, // R6 re-arm
    {3'b101, 3'b111, 1'b0, 12'(300),   12'(0),     12'(0),    1'b1, 3'b001, 3'b000}, // R6
    {3'b101, 3'b111, 1'b0, 12'(0),     12'(0),     12'(0),    1'b0, 3'b000, 3'b000}, // R6
    {3'b000, 3'b011, 1'b0, 12'(99),    12'(-99),   12'(2000), 1'b0, 3'b000, 3'b000}, // R3 freefall
    {3'b000, 3'b011, 1'b0, 12'(100),   12'(0),     12'(0),    1'b0, 3'b000, 3'b000}, // R3 equal
    {3'b000, 3'b011, 1'b0, 12'(5),     12'(5),     12'(0),    1'b0, 3'b000, 3'b000}, // R4
    {3'b000, 3'b011, 1'b0, 12'(-5),    12'(5),     12'(0),    1'b1, 3'b000, 3'b000}, // R4
    {3'b000, 3'b011, 1'b0, 12'(500),   12'(0),     12'(0),    1'b1, 3'b001, 3'b000}, // R5
    {3'b000, 3'b011, 1'b0, 12'(0),     12'(0),     12'(0),    1'b1, 3'b000, 3'b000}, // R5
    {3'b000, 3'b011, 1'b0, 12'(0),     12'(300),   12'(0),    1'b1, 3'b010, 3'b000}, // R5
    {3'b000, 3'b011, 1'b0, 12'(0),     12'(300),   12'(0),    1'b0, 3'b010, 3'b000}, // R5
    {3'b100, 3'b000, 1'b0, 12'(2047),  12'(2047),  12'(2047), 1'b0, 3'b000, 3'b000}, // R3 disabled
    {3'b110, 3'b111, 1'b0, 12'(-400),  12'(0),     12'(0),    1'b0, 3'b001, 3'b001}, // R8
    {3'b110, 3'b111, 1'b0, 12'(-400),  12'(0),     12'(0),    1'b1, 3'b001, 3'b001}, // R8
    {3'b110, 3'b111, 1'b0, 12'(0),     12'(400),   12'(0),    1'b1, 3'b001, 3'b001}, // R9 frozen
    {3'b110, 3'b111, 1'b0, 12'(0),     12'(0),     12'(0),    1'b1, 3'b001, 3'b001}, // R8 R9
    {3'b110, 3'b111, 1'b0, 12'(0),     12'(0),     12'(0),    1'b1, 3'b001, 3'b001}, // R8 R9
    {3'b110, 3'b111, 1'b1, 12'(0),     12'(0),     12'(-500), 1'b0, 3'b100, 3'b100}, // R10 collision
    {3'b110, 3'b111, 1'b0, 12'(0),     12'(0),     12'(-500), 1'b0, 3'b100, 3'b100}, // R10 not counted
    {3'b110, 3'b111, 1'b0, 12'(0),     12'(0),     12'(-500), 1'b1, 3'b100, 3'b100}, // R10
    {3'b110, 3'b111, 1'b1, 12'(0),     12'(0),     12'(0),    1'b0, 3'b000, 3'b000}  // R8 R9
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic smp(input logic mot, input logic lat, input logic clr,
                     input logic [2:0] en, input logic rd,
                     input logic [11:0] x, input logic [11:0] y, input logic [11:0] z);
    cfg_motion = mot; cfg_latch = lat; cfg_clr_mode = clr; cfg_axis_en = en;
    src_rd = rd; smp_x = x; smp_y = y; smp_z = z; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; src_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchecks++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    logic [49:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset evt", int'(evt_active), 0);
    chk("R12 reset hit", int'(axis_hit), 0);
    chk("R12 reset neg", int'(axis_neg), 0);

    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      smp(v[49], v[48], v[47], v[46:44], v[43], v[42:31], v[30:19], v[18:7]);
      chk($sformatf("row %0d evt R4 R5 R6 R7 R8 R10", i), int'(evt_active), int'(v[6]));
      chk($sformatf("row %0d hit R1 R3 R9", i), int'(axis_hit), int'(v[5:3]));
      chk($sformatf("row %0d neg R2", i), int'(axis_neg), int'(v[2:0]));
    end

    // Zero debounce: first condition sample raises, first absent sample drops.
    cfg_dbnc = 8'd0;
    smp(1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 12'(200), 12'(0), 12'(0));
    chk("R4 zero debounce rise", int'(evt_active), 1);
    smp(1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 12'(0), 12'(0), 12'(0));
    chk("R5 zero debounce fall", int'(evt_active), 0);

    // Saturation: six condition samples with debounce 3, then exactly three to fall.
    cfg_dbnc = 8'd3;
    for (int k = 0; k < 6; k++) begin
      smp(1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 12'(200), 12'(0), 12'(0));
      chk($sformatf("R4 debounce3 sample %0d", k), int'(evt_active), (k >= 2) ? 1 : 0);
    end
    for (int k = 0; k < 3; k++) begin
      smp(1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 12'(0), 12'(0), 12'(0));
      chk($sformatf("R11 saturated fall %0d", k), int'(evt_active), (k < 2) ? 1 : 0);
    end

    // Idle cycles: nothing moves without a sample strobe.
    for (int k = 0; k < 3; k++)
      smp(1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 12'(-300), 12'(0), 12'(0));
    repeat (5) @(negedge clk);
    chk("R13 idle evt", int'(evt_active), 1);
    chk("R13 idle hit", int'(axis_hit), 1);
    chk("R13 idle neg", int'(axis_neg), 1);

    // Reset in the middle of an event.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 mid reset evt", int'(evt_active), 0);
    chk("R12 mid reset hit", int'(axis_hit), 0);
    smp(1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 12'(300), 12'(0), 12'(0));
    chk("R12 counter cleared", int'(evt_active), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule